// File: doc/BRIEF.md
# Character LCD Nibble Bridge

This block places a 4-bit parallel character panel behind a small memory-mapped register window. A CPU-side bus (address, write data, read data, write strobe, read strobe, ready) reaches six word registers. Writing the instruction register or the text register sends one nibble to the panel. Each bus write carries only bits 7:4 of the written word, so software sends a full byte as two writes. Reading the instruction register starts a read of the panel's status/address byte.

The panel returns that byte as two nibbles. The bridge samples the first nibble, sets a captured flag and, when the mask allows it, raises an interrupt. When the CPU then reads the result register, the bridge fetches the second nibble by itself. That capture sets the flag again but never raises the interrupt. Every panel cycle has three phases: address setup, enable high and hold. Their lengths are given in nanoseconds and converted to system clocks from the clock frequency.

Top module: `lcd_nibble_bridge`

## Requirements
- R1: A write to offset 0x00 (instruction) or offset 0x04 (text) runs one panel write cycle. It drives bits 7:4 of the written word on `lcd_d_out`, with `lcd_rs` 0 for 0x00 and 1 for 0x04, `lcd_rw` 0 and `lcd_d_oe` 1.
- R2: A read of offset 0x00 runs one panel read cycle with `lcd_rs` 0, `lcd_rw` 1 and `lcd_d_oe` 0. `lcd_d_in` is sampled in the last clock that `lcd_e` is high. The sampled nibble is returned in bits 7:4 of offset 0x08, and all other bits of 0x08 read 0.
- R3: Bit 8 of offset 0x0C is the captured flag. A capture sets it. A bus write of the value 0 to 0x0C clears it, and a write of any other value leaves it unchanged.
- R4: Bit 0 of offset 0x10 is the interrupt enable. Bit 0 of offset 0x14 and the `irq` pin both equal the captured flag AND the enable, but only while the last capture was a first nibble.
- R5: Each panel cycle holds `lcd_rs`, `lcd_rw` and the data steady while `lcd_e` stays low for SETUP clocks, high for HIGH clocks and low again for HOLD clocks. Each count is ceil(ns × CLK_HZ / 1e9), which is 63 for 500 ns at 125 MHz.
- R6: `busy` is high from the first setup clock to the last hold clock. A bus access to 0x00 or 0x04 that arrives while a cycle is running sees `bus_ready` low and is held until it is accepted. No write is lost.
- R7: The first read of offset 0x08 after a first-nibble capture starts a second panel read cycle on its own. That capture sets the captured flag and replaces the 0x08 nibble, while `irq` and bit 0 of 0x14 stay 0.
- R8: If a capture and a clearing write to 0x0C fall in the same clock, the captured flag ends set.
- R9: After reset the flag, the enable, the result nibble, `irq`, `busy`, `lcd_e` and `lcd_d_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, held until `bus_ready` |
| bus_rd | input | 1 | Read strobe, held until `bus_ready` |
| bus_rdata | output | DATA_W | Read data, valid while `bus_rd` is high |
| bus_ready | output | 1 | Access accepted in this clock |
| irq | output | 1 | Masked capture interrupt |
| busy | output | 1 | A panel cycle is in progress |
| lcd_rs | output | 1 | Register select (0 instruction, 1 text) |
| lcd_rw | output | 1 | 1 for a read cycle |
| lcd_e | output | 1 | Enable strobe |
| lcd_d_out | output | 4 | Nibble driven to the panel |
| lcd_d_oe | output | 1 | Output enable for the data pins |
| lcd_d_in | input | 4 | Nibble returned by the panel |

## Verification
A capture of a panel nibble and a CPU write that clears the captured flag can land on the same clock edge. The bench provokes this by waiting for the enable to rise on a read cycle and counting HIGH−1 further clocks. It then holds a zero write to 0x0C over the edge on which the nibble is sampled. The result is judged at the ports: the flag must read back as set, and the interrupt must be high because the mask is on and this was a first nibble.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;

    localparam logic [7:0] OFF_INSTR = 8'h00;
    localparam logic [7:0] OFF_TEXT  = 8'h04;
    localparam logic [7:0] OFF_RES   = 8'h08;
    localparam logic [7:0] OFF_FLAG  = 8'h0C;
    localparam logic [7:0] OFF_EN    = 8'h10;
    localparam logic [7:0] OFF_PEND  = 8'h14;

    localparam int FLAG_BIT = 8;
    localparam int EN_BIT   = 0;
    localparam int NIB_LSB  = 4;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_INSTR, SEL_TEXT, SEL_RES, SEL_FLAG, SEL_EN, SEL_PEND
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD
    } phase_e;

    typedef struct packed {
        logic       rd;
        logic       rs;
        logic [3:0] nib;
    } lcd_req_t;

    function automatic reg_sel_e decode(input logic [7:0] a);
        case (a)
            OFF_INSTR: return SEL_INSTR;
            OFF_TEXT:  return SEL_TEXT;
            OFF_RES:   return SEL_RES;
            OFF_FLAG:  return SEL_FLAG;
            OFF_EN:    return SEL_EN;
            OFF_PEND:  return SEL_PEND;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic int ns_to_cycles(input longint hz, input longint ns);
        longint c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lcdb_cycle_engine.sv
module lcdb_cycle_engine
    import lcdb_pkg::*;
#(
    parameter int SETUP_CYC = 63,
    parameter int HIGH_CYC  = 63,
    parameter int HOLD_CYC  = 63
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  lcd_req_t   req,
    output logic       idle,
    output logic       cap_stb,
    output logic [3:0] cap_nib,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [3:0] lcd_d_out,
    output logic       lcd_d_oe,
    input  logic [3:0] lcd_d_in
);

    localparam int MAXC  = max3(SETUP_CYC, HIGH_CYC, HOLD_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    phase_e          ph;
    logic [CNT_W-1:0] cnt;
    lcd_req_t        cur;
    logic            active;
    logic            last;

    assign active = (ph != PH_IDLE);
    assign last   = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            cnt <= '0;
            cur <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        cur <= req;
                        ph  <= PH_SETUP;
                        cnt <= CNT_W'(SETUP_CYC - 1);
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        ph  <= PH_PULSE;
                        cnt <= CNT_W'(HIGH_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (last) begin
                        ph  <= PH_HOLD;
                        cnt <= CNT_W'(HOLD_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (last) ph <= PH_IDLE;
                    else      cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    assign idle      = !active;
    assign cap_stb   = (ph == PH_PULSE) && last && cur.rd;
    assign cap_nib   = lcd_d_in;
    assign lcd_e     = (ph == PH_PULSE);
    assign lcd_rs    = active && cur.rs;
    assign lcd_rw    = active && cur.rd;
    assign lcd_d_oe  = active && !cur.rd;
    assign lcd_d_out = lcd_d_oe ? cur.nib : 4'h0;

    // R5: enable only pulses inside an active cycle
    p_e_in_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        lcd_e |-> !idle);

    // R5: control pins steady across consecutive busy clocks
    p_pins_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!idle && $past(!idle)) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_d_out)));

    // R2: data pins never driven during a read cycle
    p_oe_off_read_r2: assert property (@(posedge clk) disable iff (rst)
        lcd_rw |-> !lcd_d_oe);

    // R6: a new cycle starts only from idle
    p_start_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (start && idle) |=> !idle);

endmodule

// File: rtl/lcdb_regfile.sv
module lcdb_regfile
    import lcdb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              irq,
    input  logic              eng_idle,
    input  logic              cap_stb,
    input  logic [3:0]        cap_nib,
    output logic              start,
    output lcd_req_t          req
);

    reg_sel_e   sel;
    logic       eng_hit;
    logic       cpu_go;
    logic       clr_wr;
    logic       res_rd;
    logic       flag_q;
    logic       en_q;
    logic [3:0] nib_q;
    logic       low_pend;
    logic       cur_low;
    logic       last_low;
    logic       hi_wait;
    logic       pend;

    assign sel     = decode(8'(bus_addr));
    assign eng_hit = (bus_wr && (sel == SEL_INSTR || sel == SEL_TEXT))
                   || (bus_rd && !bus_wr && sel == SEL_INSTR);
    assign cpu_go  = eng_hit && eng_idle && !low_pend;
    assign start   = eng_idle && (low_pend || eng_hit);
    assign bus_ready = !eng_hit || cpu_go;
    assign clr_wr  = bus_wr && (sel == SEL_FLAG) && (bus_wdata == '0);
    assign res_rd  = bus_rd && !bus_wr && (sel == SEL_RES);

    always_comb begin
        if (low_pend)
            req = '{rd: 1'b1, rs: 1'b0, nib: 4'h0};
        else if (bus_wr)
            req = '{rd: 1'b0, rs: (sel == SEL_TEXT), nib: bus_wdata[NIB_LSB+3:NIB_LSB]};
        else
            req = '{rd: 1'b1, rs: 1'b0, nib: 4'h0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q   <= 1'b0;
            en_q     <= 1'b0;
            nib_q    <= 4'h0;
            low_pend <= 1'b0;
            cur_low  <= 1'b0;
            last_low <= 1'b0;
            hi_wait  <= 1'b0;
        end else begin
            if (cap_stb)     flag_q <= 1'b1;
            else if (clr_wr) flag_q <= 1'b0;

            if (bus_wr && sel == SEL_EN) en_q <= bus_wdata[EN_BIT];

            if (start) cur_low <= low_pend;

            if (cap_stb) begin
                nib_q    <= cap_nib;
                last_low <= cur_low;
                hi_wait  <= !cur_low;
            end else if (res_rd && hi_wait) begin
                hi_wait <= 1'b0;
            end

            if (res_rd && hi_wait)       low_pend <= 1'b1;
            else if (start && low_pend)  low_pend <= 1'b0;
        end
    end

    assign pend = flag_q && en_q && !last_low;
    assign irq  = pend;

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_RES:  bus_rdata[NIB_LSB+3:NIB_LSB] = nib_q;
            SEL_FLAG: bus_rdata[FLAG_BIT] = flag_q;
            SEL_EN:   bus_rdata[EN_BIT] = en_q;
            SEL_PEND: bus_rdata[0] = pend;
            default:  bus_rdata = '0;
        endcase
    end

    // R8: a capture always leaves the flag set
    p_cap_sets_r8: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> flag_q);

    // R3: a zero write without a capture clears the flag
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !cap_stb) |=> !flag_q);

    // R7: a second-nibble capture never raises the interrupt
    p_low_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (cap_stb && cur_low) |=> !irq);

    // R6: accesses to the panel registers are held off while a cycle runs
    p_hold_off_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (sel == SEL_INSTR || sel == SEL_TEXT) && !eng_idle) |-> !bus_ready);

endmodule

// File: rtl/lcd_nibble_bridge.sv
module lcd_nibble_bridge
    import lcdb_pkg::*;
#(
    parameter int    ADDR_W   = 8,
    parameter int    DATA_W   = 32,
    parameter longint CLK_HZ  = 125_000_000,
    parameter longint SETUP_NS = 500,
    parameter longint HIGH_NS  = 500,
    parameter longint HOLD_NS  = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              irq,
    output logic              busy,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_e,
    output logic [3:0]        lcd_d_out,
    output logic              lcd_d_oe,
    input  logic [3:0]        lcd_d_in
);

    localparam int SETUP_CYC = ns_to_cycles(CLK_HZ, SETUP_NS);
    localparam int HIGH_CYC  = ns_to_cycles(CLK_HZ, HIGH_NS);
    localparam int HOLD_CYC  = ns_to_cycles(CLK_HZ, HOLD_NS);

    logic       eng_idle;
    logic       cap_stb;
    logic [3:0] cap_nib;
    logic       start;
    lcd_req_t   req;

    lcdb_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .irq       (irq),
        .eng_idle  (eng_idle),
        .cap_stb   (cap_stb),
        .cap_nib   (cap_nib),
        .start     (start),
        .req       (req)
    );

    lcdb_cycle_engine #(
        .SETUP_CYC (SETUP_CYC),
        .HIGH_CYC  (HIGH_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) eng_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req       (req),
        .idle      (eng_idle),
        .cap_stb   (cap_stb),
        .cap_nib   (cap_nib),
        .lcd_rs    (lcd_rs),
        .lcd_rw    (lcd_rw),
        .lcd_e     (lcd_e),
        .lcd_d_out (lcd_d_out),
        .lcd_d_oe  (lcd_d_oe),
        .lcd_d_in  (lcd_d_in)
    );

    assign busy = !eng_idle;

    // R6: busy and bus acceptance of a panel write never coincide
    p_busy_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_wr && (bus_addr == ADDR_W'(OFF_TEXT))) |-> !bus_ready);

endmodule

// File: tb/lcd_nibble_bridge_tb_top.sv
`timescale 1ns/1ps
module lcd_nibble_bridge_tb_top;

    localparam int PH_CYC = 63; // ceil(500 ns * 125 MHz)

    typedef struct { logic rs; logic [3:0] nib; } wr_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_ready, irq, busy, lcd_rs, lcd_rw, lcd_e, lcd_d_oe;
    logic [3:0]  lcd_d_out;
    logic [3:0]  panel_nib = 4'h0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    wr_item_t exp_q[$];

    always #4 clk = ~clk;

    lcd_nibble_bridge dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .irq(irq), .busy(busy), .lcd_rs(lcd_rs),
        .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_d_out(lcd_d_out),
        .lcd_d_oe(lcd_d_oe), .lcd_d_in(panel_nib)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: panel writes push the expected item before the access
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output bit stalled);
        stalled = 0;
        if (a == 8'h00 || a == 8'h04) begin
            wr_item_t it;
            it.rs = (a == 8'h04);
            it.nib = d[7:4];
            exp_q.push_back(it);
        end
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        forever begin
            #1;
            if (bus_ready) break;
            stalled = 1;
            @(negedge clk);
        end
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        forever begin
            #1;
            if (bus_ready) break;
            @(negedge clk);
        end
        d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(posedge clk);
        while (busy) @(posedge clk);
        @(negedge clk);
    endtask

    // monitor: every write strobe's falling edge pops and compares
    always @(negedge lcd_e) begin
        if (!rst && !lcd_rw) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected write", 32'(lcd_d_out), 32'hFFFF_FFFF);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk("R1 rs", 32'(lcd_rs), 32'(it.rs));
                chk("R1 nibble", 32'(lcd_d_out), 32'(it.nib));
                chk("R1 oe", 32'(lcd_d_oe), 32'd1);
            end
        end
    end

    // R5 phase length monitor for the first few cycles
    int su = 0, hi = 0, ho = 0, n_cyc = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (lcd_e) hi++;
            else if (busy && hi == 0) su++;
            else if (busy) ho++;
            if (!busy && (su + hi + ho) != 0) begin
                if (n_cyc < 3) begin
                    chk("R5 setup", 32'(su), 32'(PH_CYC));
                    chk("R5 high", 32'(hi), 32'(PH_CYC));
                    chk("R5 hold", 32'(ho), 32'(PH_CYC));
                end
                n_cyc++;
                su = 0; hi = 0; ho = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        bit st;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 irq", 32'(irq), 0);
        chk("R9 busy", 32'(busy), 0);
        chk("R9 e", 32'(lcd_e), 0);
        chk("R9 oe", 32'(lcd_d_oe), 0);
        bus_read(8'h0C, r); chk("R9 flag", r, 0);
        bus_read(8'h10, r); chk("R9 enable", r, 0);
        bus_read(8'h08, r); chk("R9 result", r, 0);

        // R1 / R6: instruction then text write back to back
        bus_write(8'h00, 32'h0000_013C, st);
        bus_write(8'h04, 32'hFFFF_FFA5, st);
        chk("R6 second write stalled", 32'(st), 1);
        chk("R6 busy during cycle", 32'(busy), 1);
        bus_write(8'h04, 32'h0000_0070, st);
        wait_idle();

        // R2 / R3 / R4: first nibble read with interrupt enabled
        bus_write(8'h10, 32'h1, st);
        panel_nib = 4'h9;
        bus_read(8'h00, r);
        @(posedge lcd_e); #1;
        chk("R2 rw", 32'(lcd_rw), 1);
        chk("R2 rs", 32'(lcd_rs), 0);
        chk("R2 oe", 32'(lcd_d_oe), 0);
        chk("R4 irq before capture", 32'(irq), 0);
        wait_idle();
        chk("R4 irq", 32'(irq), 1);
        bus_read(8'h0C, r); chk("R3 flag set", r, 32'h100);
        bus_read(8'h14, r); chk("R4 masked", r, 32'h1);
        bus_write(8'h0C, 32'h100, st);
        bus_read(8'h0C, r); chk("R3 nonzero write keeps", r, 32'h100);
        bus_write(8'h0C, 32'h0, st);
        bus_read(8'h0C, r); chk("R3 zero write clears", r, 0);
        chk("R4 irq after clear", 32'(irq), 0);

        // R7: reading result fetches the second nibble silently
        panel_nib = 4'h6;
        bus_read(8'h08, r); chk("R2 result high", r, 32'h90);
        wait_idle();
        bus_read(8'h0C, r); chk("R7 flag set", r, 32'h100);
        chk("R7 irq quiet", 32'(irq), 0);
        bus_read(8'h14, r); chk("R7 masked quiet", r, 0);
        bus_read(8'h08, r); chk("R7 result low", r, 32'h60);
        bus_write(8'h0C, 32'h0, st);

        // R4: disabled mask hides the flag, enabling shows it
        bus_write(8'h10, 32'h0, st);
        panel_nib = 4'hC;
        bus_read(8'h00, r);
        wait_idle();
        chk("R4 irq masked", 32'(irq), 0);
        bus_read(8'h14, r); chk("R4 masked off", r, 0);
        bus_write(8'h10, 32'h1, st);
        chk("R4 irq after enable", 32'(irq), 1);
        bus_write(8'h0C, 32'h0, st);
        bus_read(8'h08, r); chk("R2 result C", r, 32'hC0);
        wait_idle();
        bus_write(8'h0C, 32'h0, st);

        // R8: clearing write on the capture edge
        panel_nib = 4'h3;
        bus_read(8'h00, r);
        @(posedge lcd_e);
        repeat (PH_CYC - 1) @(posedge clk);
        @(negedge clk);
        bus_addr = 8'h0C; bus_wdata = 32'h0; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        bus_read(8'h0C, r); chk("R8 capture wins", r, 32'h100);
        chk("R8 irq", 32'(irq), 1);
        bus_read(8'h08, r); chk("R8 result", r, 32'h30);
        wait_idle();

        chk("R6 no write dropped", 32'(exp_q.size()), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule